// File: doc/BRIEF.md
# Per-Thread Deadline Timer Unit

This unit holds a bank of countdown timers for a processor that issues instructions from several hardware threads in a fixed rotation. Each thread owns a small set of timers. When the decode stage sees a deadline instruction, it presents the issuing thread, the timer index and the immediate value. The unit then decides in the same cycle. If the addressed timer has not yet reached zero, the instruction is refused and the thread is flagged for replay: on its next turn it fetches the same program counter again. If the timer has reached zero, the thread proceeds and the timer is re-armed with the immediate. A block of code bracketed by two deadline instructions therefore takes at least the armed number of cycles.

All timers count down by one every clock cycle on their own and stop at zero. Any timer can be read back through a separate read port that is addressed by thread and index. The pipeline holds back the program counter increment whenever the replay flag is raised. The pipeline, decode and register file sit outside this block.

Top module: `deadline_timer_unit`

## Requirements
- R1: A synchronous active-high reset clears every timer to zero, including timers that are counting at the time of the reset.
- R2: A valid deadline request whose addressed timer is non-zero raises `replay` and lowers `proceed` in that same cycle. The timer is not reloaded and keeps counting down.
- R3: A valid deadline request whose addressed timer is zero raises `proceed` and lowers `replay` in that same cycle. The timer holds the request's immediate value from the next cycle on.
- R4: Every non-zero timer decreases by exactly one per clock cycle, across the full 32-bit range.
- R5: A timer at zero stays at zero and never wraps.
- R6: When a load and the automatic decrement meet on the same timer in one cycle, the load wins. The timer shows the immediate, not the immediate minus one.
- R7: An immediate of zero is accepted. A later deadline request on that timer proceeds without any stall.
- R8: Timers are selected by the pair (thread, index), with 6 threads and 4 timers per thread. A load changes only the addressed timer, and a request on one timer is never stalled by another timer.
- R9: A request naming thread 6 or 7 raises neither flag and changes no timer. Reading back thread 6 or 7 returns zero.
- R10: With `dl_valid` low, both `replay` and `proceed` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dl_valid | input | 1 | A deadline instruction is being decoded this cycle |
| dl_thread | input | 3 | Issuing thread id |
| dl_index | input | 2 | Timer index within the thread's set |
| dl_imm | input | 32 | Value to arm the timer with |
| rd_thread | input | 3 | Read-back thread id |
| rd_index | input | 2 | Read-back timer index |
| rd_value | output | 32 | Current value of the addressed timer, zero if out of range |
| replay | output | 1 | Deadline not yet met: the thread re-executes the same program counter |
| proceed | output | 1 | Deadline met: the timer is re-armed and the program counter advances |

## Verification
The hardest situation to reach is a thread that keeps re-issuing the same deadline instruction while its timer drains. The stall has to persist for exactly as many cycles as the timer held, and it has to release on the cycle the timer reads zero. The bench reaches this by arming a timer, then holding the request high cycle after cycle and counting replay cycles until `proceed` appears. It then checks that the count matches the armed value and that the new immediate was taken. The load-versus-decrement overlap is reached by arming a timer straight from zero and reading it back one cycle later. Out-of-range threads are covered by a reset followed by a sweep of the whole bank.

// File: rtl/dtu_pkg.sv
`timescale 1ns/1ps
package dtu_pkg;

    // Bank geometry
    localparam int NUM_THREADS       = 6;
    localparam int TIMERS_PER_THREAD = 4;
    localparam int TIMER_W           = 32;

    // Derived widths
    localparam int TID_W     = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;
    localparam int IDX_W     = (TIMERS_PER_THREAD > 1) ? $clog2(TIMERS_PER_THREAD) : 1;
    localparam int NUM_TIMERS = NUM_THREADS * TIMERS_PER_THREAD;
    localparam int SLOT_W    = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1;

    typedef logic [TIMER_W-1:0] timer_t;
    typedef logic [TID_W-1:0]   tid_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [SLOT_W-1:0]  slot_t;

    // One deadline request as seen by the unit
    typedef struct packed {
        logic   valid;
        tid_t   tid;
        idx_t   idx;
        timer_t imm;
    } dl_req_t;

    // Decision taken on a request
    typedef enum logic [1:0] {
        DL_IDLE    = 2'd0,
        DL_PROCEED = 2'd1,
        DL_REPLAY  = 2'd2,
        DL_DROP    = 2'd3
    } dl_outcome_e;

    // Flat position of a timer inside the bank
    function automatic slot_t slot_of(tid_t tid, idx_t idx);
        return SLOT_W'(int'(tid) * TIMERS_PER_THREAD + int'(idx));
    endfunction

    // Whether a (thread, index) pair names an existing timer
    function automatic logic in_range(tid_t tid, idx_t idx);
        return (int'(tid) < NUM_THREADS) && (int'(idx) < TIMERS_PER_THREAD);
    endfunction

endpackage

// File: rtl/dtu_timer_cell.sv
`timescale 1ns/1ps
module dtu_timer_cell #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value
);

    logic [W-1:0] count_q;
    logic         expired;

    assign expired = (count_q == '0);

    // A load takes priority over the free-running decrement
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load_en) begin
            count_q <= load_val;
        end else if (!expired) begin
            count_q <= count_q - W'(1);
        end
    end

    assign value = count_q;

    assert_load_wins_R6: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (value == $past(load_val)));

    assert_count_down_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_en && value != '0) |=> (value == $past(value) - W'(1)));

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (!load_en && value == '0) |=> (value == '0));

endmodule

// File: rtl/dtu_read_mux.sv
`timescale 1ns/1ps
module dtu_read_mux #(
    parameter int N  = 24,
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  logic [N-1:0][W-1:0] bank,
    input  logic [SW-1:0]       sel,
    input  logic                sel_ok,
    output logic [W-1:0]        data
);

    always_comb begin
        data = '0;
        for (int k = 0; k < N; k++) begin
            if (sel_ok && (int'(sel) == k)) begin
                data = bank[k];
            end
        end
    end

endmodule

// File: rtl/dtu_decide.sv
`timescale 1ns/1ps
module dtu_decide
    import dtu_pkg::*;
#(
    parameter int N = NUM_TIMERS
) (
    input  logic            clk,
    input  logic            rst,
    input  dl_req_t         req,
    input  timer_t          cur_value,
    output dl_outcome_e     outcome,
    output slot_t           slot,
    output logic [N-1:0]    load_vec
);

    logic hit;

    assign hit  = in_range(req.tid, req.idx);
    assign slot = slot_of(req.tid, req.idx);

    always_comb begin
        if (!req.valid) begin
            outcome = DL_IDLE;
        end else if (!hit) begin
            outcome = DL_DROP;
        end else if (cur_value != '0) begin
            outcome = DL_REPLAY;
        end else begin
            outcome = DL_PROCEED;
        end
    end

    // Only a proceeding request writes, and only its own slot
    generate
        for (genvar g = 0; g < N; g++) begin : g_load
            assign load_vec[g] = (outcome == DL_PROCEED) && (int'(slot) == g);
        end
    endgenerate

    assert_single_write_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_vec));

    assert_drop_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        (req.valid && !in_range(req.tid, req.idx)) |-> (load_vec == '0));

endmodule

// File: rtl/deadline_timer_unit.sv
`timescale 1ns/1ps
module deadline_timer_unit
    import dtu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               dl_valid,
    input  logic [TID_W-1:0]   dl_thread,
    input  logic [IDX_W-1:0]   dl_index,
    input  logic [TIMER_W-1:0] dl_imm,
    input  logic [TID_W-1:0]   rd_thread,
    input  logic [IDX_W-1:0]   rd_index,
    output logic [TIMER_W-1:0] rd_value,
    output logic               replay,
    output logic               proceed
);

    dl_req_t                               req;
    logic [NUM_TIMERS-1:0][TIMER_W-1:0]    bank;
    logic [NUM_TIMERS-1:0]                 load_vec;
    timer_t                                cur_value;
    dl_outcome_e                           outcome;
    slot_t                                 req_slot;

    assign req = '{valid: dl_valid, tid: dl_thread, idx: dl_index, imm: dl_imm};

    // Timer storage: one cell per (thread, index)
    generate
        for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_cell
            dtu_timer_cell #(.W(TIMER_W)) u_cell (
                .clk      (clk),
                .rst      (rst),
                .load_en  (load_vec[g]),
                .load_val (req.imm),
                .value    (bank[g])
            );
        end
    endgenerate

    // Lookup of the timer addressed by the request
    dtu_read_mux #(.N(NUM_TIMERS), .W(TIMER_W), .SW(SLOT_W)) u_req_mux (
        .bank   (bank),
        .sel    (slot_of(req.tid, req.idx)),
        .sel_ok (in_range(req.tid, req.idx)),
        .data   (cur_value)
    );

    dtu_decide #(.N(NUM_TIMERS)) u_decide (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .cur_value (cur_value),
        .outcome   (outcome),
        .slot      (req_slot),
        .load_vec  (load_vec)
    );

    // Read-back port
    dtu_read_mux #(.N(NUM_TIMERS), .W(TIMER_W), .SW(SLOT_W)) u_rd_mux (
        .bank   (bank),
        .sel    (slot_of(rd_thread, rd_index)),
        .sel_ok (in_range(rd_thread, rd_index)),
        .data   (rd_value)
    );

    assign replay  = (outcome == DL_REPLAY);
    assign proceed = (outcome == DL_PROCEED);

    assert_stall_keeps_count_R2: assert property (@(posedge clk) disable iff (rst)
        replay |=> (bank[$past(req_slot)] == $past(cur_value) - TIMER_W'(1)));

    assert_proceed_arms_R3: assert property (@(posedge clk) disable iff (rst)
        proceed |=> (bank[$past(req_slot)] == $past(dl_imm)));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !dl_valid |-> (!replay && !proceed));

    assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(replay && proceed));

endmodule

// File: tb/deadline_timer_unit_tb.sv
`timescale 1ns/1ps
module deadline_timer_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dl_valid = 1'b0;
    logic [2:0]  dl_thread = '0;
    logic [1:0]  dl_index = '0;
    logic [31:0] dl_imm = '0;
    logic [2:0]  rd_thread = '0;
    logic [1:0]  rd_index = '0;
    logic [31:0] rd_value;
    logic        replay;
    logic        proceed;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    deadline_timer_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .dl_valid  (dl_valid),
        .dl_thread (dl_thread),
        .dl_index  (dl_index),
        .dl_imm    (dl_imm),
        .rd_thread (rd_thread),
        .rd_index  (rd_index),
        .rd_value  (rd_value),
        .replay    (replay),
        .proceed   (proceed)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance to 1 ns past the next rising edge
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic [2:0] t, input logic [1:0] i, input logic [31:0] v);
        dl_valid  = 1'b1;
        dl_thread = t;
        dl_index  = i;
        dl_imm    = v;
    endtask

    task automatic idle();
        dl_valid = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [2:0] t, input logic [1:0] i,
                            input logic [31:0] exp);
        rd_thread = t;
        rd_index  = i;
        #0.02;
        check(req, rd_value, exp);
    endtask

    task automatic flags_chk(input string req, input logic exp_rep, input logic exp_pro);
        #0.5;
        check({req, " replay"}, {31'd0, replay}, {31'd0, exp_rep});
        check({req, " proceed"}, {31'd0, proceed}, {31'd0, exp_pro});
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        cyc();
        cyc();
        rst = 1'b0;
    endtask

    // R1: every timer reads zero after reset
    task automatic t_reset_state();
        do_reset();
        for (int t = 0; t < 6; t++) begin
            for (int i = 0; i < 4; i++) begin
                read_chk("R1 reset bank", 3'(t), 2'(i), 32'd0);
            end
        end
    endtask

    // R3, R4, R5, R6: arm from zero, count down, hold at zero
    task automatic t_arm_and_drain();
        drive(3'd1, 2'd2, 32'd5);
        flags_chk("R3 arm t1i2", 1'b0, 1'b1);
        cyc();
        idle();
        read_chk("R6 load not decremented", 3'd1, 2'd2, 32'd5);
        cyc();
        read_chk("R4 first decrement", 3'd1, 2'd2, 32'd4);
        repeat (4) cyc();
        read_chk("R4 reaches zero", 3'd1, 2'd2, 32'd0);
        cyc();
        read_chk("R5 stays at zero", 3'd1, 2'd2, 32'd0);
        repeat (3) cyc();
        read_chk("R5 no wrap", 3'd1, 2'd2, 32'd0);
    endtask

    // R2: repeated requests stall until expiry, then re-arm
    task automatic t_stall_chain();
        int stalls;
        drive(3'd2, 2'd0, 32'd8);
        flags_chk("R3 arm t2i0", 1'b0, 1'b1);
        cyc();
        drive(3'd2, 2'd0, 32'd3);
        flags_chk("R2 stall on nonzero", 1'b1, 1'b0);
        cyc();
        read_chk("R2 stall keeps counting", 3'd2, 2'd0, 32'd7);
        stalls = 1;
        for (int k = 0; k < 20; k++) begin
            #0.5;
            if (!replay) break;
            stalls++;
            cyc();
        end
        check("R2 replay cycle count", 32'(stalls), 32'd8);
        flags_chk("R2 release at zero", 1'b0, 1'b1);
        cyc();
        idle();
        read_chk("R3 rearmed after stall", 3'd2, 2'd0, 32'd3);
    endtask

    // R7: zero immediate leaves no constraint
    task automatic t_zero_imm();
        drive(3'd3, 2'd1, 32'd0);
        flags_chk("R7 arm with zero", 1'b0, 1'b1);
        cyc();
        read_chk("R7 timer zero", 3'd3, 2'd1, 32'd0);
        drive(3'd3, 2'd1, 32'd4);
        flags_chk("R7 next deadline free", 1'b0, 1'b1);
        cyc();
        idle();
        read_chk("R7 second arm taken", 3'd3, 2'd1, 32'd4);
    endtask

    // R8: timers are independent by thread and by index
    task automatic t_independence();
        drive(3'd4, 2'd3, 32'd20);
        cyc();
        idle();
        read_chk("R8 target loaded", 3'd4, 2'd3, 32'd20);
        read_chk("R8 sibling index untouched", 3'd4, 2'd2, 32'd0);
        read_chk("R8 other thread untouched", 3'd5, 2'd3, 32'd0);
        drive(3'd5, 2'd3, 32'd6);
        flags_chk("R8 no cross stall", 1'b0, 1'b1);
        cyc();
        idle();
        read_chk("R8 other thread armed", 3'd5, 2'd3, 32'd6);
        read_chk("R8 first timer still counting", 3'd4, 2'd3, 32'd19);
    endtask

    // R9, R10: out-of-range threads and idle cycles
    task automatic t_out_of_range();
        do_reset();
        drive(3'd6, 2'd0, 32'd9);
        flags_chk("R9 thread 6", 1'b0, 1'b0);
        cyc();
        drive(3'd7, 2'd3, 32'd9);
        flags_chk("R9 thread 7", 1'b0, 1'b0);
        cyc();
        idle();
        for (int t = 0; t < 6; t++) begin
            for (int i = 0; i < 4; i++) begin
                read_chk("R9 bank unchanged", 3'(t), 2'(i), 32'd0);
            end
        end
        read_chk("R9 read thread 6", 3'd6, 2'd0, 32'd0);
        read_chk("R9 read thread 7", 3'd7, 2'd3, 32'd0);
        // Arm a timer, then present its address with valid low
        drive(3'd1, 2'd1, 32'd10);
        cyc();
        dl_valid = 1'b0;
        flags_chk("R10 idle on busy timer", 1'b0, 1'b0);
        dl_index = 2'd0;
        flags_chk("R10 idle on free timer", 1'b0, 1'b0);
    endtask

    // R1: reset while counting
    task automatic t_reset_midcount();
        drive(3'd0, 2'd0, 32'd100);
        cyc();
        idle();
        cyc();
        read_chk("R1 counting before reset", 3'd0, 2'd0, 32'd99);
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        read_chk("R1 cleared by reset", 3'd0, 2'd0, 32'd0);
        read_chk("R1 other counter cleared", 3'd1, 2'd1, 32'd0);
    endtask

    // R4: full-width value
    task automatic t_full_width();
        drive(3'd5, 2'd0, 32'hFFFF_FFFF);
        cyc();
        idle();
        read_chk("R4 max loaded", 3'd5, 2'd0, 32'hFFFF_FFFF);
        cyc();
        read_chk("R4 max decremented", 3'd5, 2'd0, 32'hFFFF_FFFE);
        drive(3'd5, 2'd0, 32'd1);
        flags_chk("R2 stall on large value", 1'b1, 1'b0);
        cyc();
        idle();
        read_chk("R2 large value not reloaded", 3'd5, 2'd0, 32'hFFFF_FFFD);
    endtask

    initial begin
        t_reset_state();
        t_arm_and_drain();
        t_stall_chain();
        t_zero_imm();
        t_independence();
        t_out_of_range();
        t_reset_midcount();
        t_full_width();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all requirements actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule